// File: doc/BRIEF.md
# Speculative Commit Shadow Matrix

This block gates register-file writes for a scoreboard with a parameterised number of function units. Some instructions may later turn out to be unwanted: a branch that may be mispredicted, or a load or store that may fault. When such an instruction is issued as a shadower, it casts a shadow over every unit issued after it while the shadow is live. The shadow covers those units whether or not they depend on the shadower. A shadowed unit may compute freely, but it is not allowed to write back. A shadower reports success, which lifts its shadow, or failure, which cancels every unit under that shadow in one cycle. A global fail-all input makes every live shadower fail at once.

The state is a square bit matrix. Row i lists the units that unit i shadows, so column j lists the shadows over unit j. A unit is granted its write only when its column is empty. A granted or cancelled unit goes back to idle, and its row and column are wiped. Nothing is buffered or restored. Cancellation only means a unit is never allowed to write.

Top module: `shadow_commit_matrix`

## Requirements
- R1: After reset, and after any later reset, every unit is idle. `go_write` and `go_die` stay zero whatever `wr_req` is set to.
- R2: An issued non-shadower with an empty column is granted `go_write` in the same cycle as its `wr_req`, starting from the cycle after its issue.
- R3: On issue, the new unit becomes shadowed by every live shadower, dependent or not. While any shadow covers it, its `wr_req` gets no `go_write`.
- R4: A unit issued with `issue_shadow`=1 gets no `go_write` until its own shadow has been resolved by success, failure or fail-all.
- R5: `shadow_ok[i]` on a live shadower i lifts its shadow. Units that no other shadow covers are granted from the next cycle on. The shadower becomes an ordinary unit.
- R6: `shadow_fail[i]` on a live shadower i raises `go_die` in the same cycle for exactly the busy units issued after i while i was live. Earlier units and i itself are not cancelled.
- R7: `fail_all` acts as a failure on every live shadower in the same cycle.
- R8: A unit that receives `go_write` or `go_die` is idle from the next cycle on. It then gets no grant until it is issued again.
- R9: When a shadower resolves in the same cycle as an issue, the new unit is not placed under that shadower and is not cancelled by it.
- R10: `shadow_ok` or `shadow_fail` on a unit that is not a live shadower has no effect.
- R11: An issue to a unit that is already busy is ignored, and the unit keeps its earlier kind (shadower or not).
- R12: When `shadow_ok[i]` and `shadow_fail[i]` arrive together, the failure wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_vld | input | 1 | An instruction is issued this cycle |
| issue_fu | input | IDX_W | Index of the unit being issued |
| issue_shadow | input | 1 | The issued instruction may be cancelled (becomes a shadower) |
| shadow_ok | input | NUM_FU | Per-shadower success: its shadow can never be needed |
| shadow_fail | input | NUM_FU | Per-shadower failure: cancel everything under it |
| fail_all | input | 1 | Fail every live shadower at once |
| wr_req | input | NUM_FU | Per-unit result ready, asking to write |
| go_write | output | NUM_FU | Per-unit write permission |
| go_die | output | NUM_FU | Per-unit cancel |

## Verification
Two pairs of events can land in the same clock cycle. In the first pair, a shadower resolves while a new unit is issued. The vectors issue a unit in the same cycle as another shadower's success, and again in the same cycle as a failure. The bench then judges by which units are cancelled at once and which units write in the following cycle. In the second pair, a failure arrives while shadowed units hold `wr_req` high. The bench expects `go_die` on exactly the later units, with no `go_write` in that cycle.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

   // Life cycle of one function unit as seen by the shadow logic.
   typedef enum logic [1:0] {
      FU_IDLE   = 2'd0,
      FU_PLAIN  = 2'd1,
      FU_SHADOW = 2'd2
   } fu_state_e;

   function automatic logic fu_busy(input fu_state_e st);
      return st != FU_IDLE;
   endfunction

endpackage

// File: rtl/ssm_unit.sv
module ssm_unit
   import ssm_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic issue_here,
   input  logic issue_shadow,
   input  logic ok_in,
   input  logic fail_in,
   input  logic fail_all,
   input  logic wr_req,
   input  logic col_hit,
   input  logic kill_hit,
   output logic idle,
   output logic shadow_live,
   output logic fail_eff,
   output logic clr_row,
   output logic go_write,
   output logic go_die
);

   fu_state_e st_q, st_d;
   logic      resolve;

   always_comb begin
      idle        = !fu_busy(st_q);
      fail_eff    = (st_q == FU_SHADOW) && (fail_in || fail_all);
      resolve     = (st_q == FU_SHADOW) && (ok_in || fail_eff);
      go_write    = (st_q == FU_PLAIN) && wr_req && !col_hit;
      go_die      = fu_busy(st_q) && kill_hit;
      shadow_live = (st_q == FU_SHADOW) && !resolve && !kill_hit;
      clr_row     = resolve || go_write || go_die;
   end

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         FU_IDLE:   if (issue_here) st_d = issue_shadow ? FU_SHADOW : FU_PLAIN;
         FU_PLAIN:  if (go_write || go_die) st_d = FU_IDLE;
         FU_SHADOW: if (go_die) st_d = FU_IDLE;
                    else if (resolve) st_d = FU_PLAIN;
         default:   st_d = FU_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= FU_IDLE;
      else        st_q <= st_d;
   end

   // R11: an accepted issue always leaves the unit busy next cycle
   p_issue_taken_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_here && idle) |=> !idle);

   // R8: a granted write leaves the unit idle next cycle
   p_write_retires_r8: assert property (@(posedge clk) disable iff (!rst_n)
      go_write |=> (idle && !go_write));

   // R4: a shadower is never granted before it resolves
   p_shadower_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (shadow_live) |=> !go_write);

endmodule

// File: rtl/ssm_row.sv
module ssm_row #(
   parameter int NUM_FU = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_row,
   input  logic [NUM_FU-1:0] clr_col,
   input  logic [NUM_FU-1:0] set_col,
   output logic [NUM_FU-1:0] row_q
);

   logic [NUM_FU-1:0] row_d;

   always_comb begin
      if (clr_row) row_d = '0;
      else         row_d = (row_q & ~clr_col) | set_col;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) row_q <= '0;
      else        row_q <= row_d;
   end

   // R5 / R6: a resolved or retired shadower holds no shadow next cycle
   p_row_wiped_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_row |=> (row_q == '0));

endmodule

// File: rtl/shadow_commit_matrix.sv
module shadow_commit_matrix
   import ssm_pkg::*;
#(
   parameter  int NUM_FU = 4,
   localparam int IDX_W  = (NUM_FU > 1) ? $clog2(NUM_FU) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_vld,
   input  logic [IDX_W-1:0]  issue_fu,
   input  logic              issue_shadow,
   input  logic [NUM_FU-1:0] shadow_ok,
   input  logic [NUM_FU-1:0] shadow_fail,
   input  logic              fail_all,
   input  logic [NUM_FU-1:0] wr_req,
   output logic [NUM_FU-1:0] go_write,
   output logic [NUM_FU-1:0] go_die
);

   if (NUM_FU < 2 || NUM_FU > 64) begin : g_bad_size
      $error("shadow_commit_matrix: NUM_FU must lie in 2..64");
   end

   logic [NUM_FU-1:0] issue_dec;
   logic [NUM_FU-1:0] issue_acc;
   logic [NUM_FU-1:0] idle;
   logic [NUM_FU-1:0] live;
   logic [NUM_FU-1:0] fail_eff;
   logic [NUM_FU-1:0] clr_row;
   logic [NUM_FU-1:0] retire;
   logic [NUM_FU-1:0] col_hit;
   logic [NUM_FU-1:0] kill_hit;
   logic [NUM_FU-1:0] mtx [NUM_FU];

   for (genvar j = 0; j < NUM_FU; j++) begin : g_dec
      assign issue_dec[j] = issue_vld && (issue_fu == IDX_W'(j));
   end

   assign issue_acc = issue_dec & idle;
   assign retire    = go_write | go_die;

   // Column reductions: any shadow over unit j, and any failing shadow over it.
   always_comb begin
      col_hit  = '0;
      kill_hit = '0;
      for (int i = 0; i < NUM_FU; i++) begin
         for (int j = 0; j < NUM_FU; j++) begin
            col_hit[j]  = col_hit[j]  | mtx[i][j];
            kill_hit[j] = kill_hit[j] | (mtx[i][j] & fail_eff[i]);
         end
      end
   end

   for (genvar i = 0; i < NUM_FU; i++) begin : g_fu
      ssm_unit u_unit (
         .clk          (clk),
         .rst_n        (rst_n),
         .issue_here   (issue_dec[i]),
         .issue_shadow (issue_shadow),
         .ok_in        (shadow_ok[i]),
         .fail_in      (shadow_fail[i]),
         .fail_all     (fail_all),
         .wr_req       (wr_req[i]),
         .col_hit      (col_hit[i]),
         .kill_hit     (kill_hit[i]),
         .idle         (idle[i]),
         .shadow_live  (live[i]),
         .fail_eff     (fail_eff[i]),
         .clr_row      (clr_row[i]),
         .go_write     (go_write[i]),
         .go_die       (go_die[i])
      );

      ssm_row #(.NUM_FU(NUM_FU)) u_row (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr_row (clr_row[i]),
         .clr_col (retire),
         .set_col (issue_acc & {NUM_FU{live[i]}}),
         .row_q   (mtx[i])
      );
   end

   // R6: write and cancel never coincide on one unit
   p_write_die_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (go_write & go_die) == '0);

   // R8: an idle unit receives neither grant nor cancel
   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((go_write | go_die) & idle) == '0);

   // R8: a retired unit's column is empty afterwards
   p_col_wiped_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (retire != '0) |=> ((col_hit & $past(retire)) == '0));

   // R3 / R9: a freshly issued unit is shadowed exactly when a live shadower existed
   p_new_col_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_acc != '0) |=> (((col_hit & $past(issue_acc)) != '0) == $past(live != '0)));

endmodule

// File: tb/sim_shadow_commit_matrix.sv
module sim_shadow_commit_matrix;

   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         issue_vld = 1'b0;
   logic [1:0]   issue_fu = '0;
   logic         issue_shadow = 1'b0;
   logic [N-1:0] shadow_ok = '0;
   logic [N-1:0] shadow_fail = '0;
   logic         fail_all = 1'b0;
   logic [N-1:0] wr_req = '0;
   logic [N-1:0] go_write;
   logic [N-1:0] go_die;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   shadow_commit_matrix #(.NUM_FU(N)) u0 (
      .clk, .rst_n, .issue_vld, .issue_fu, .issue_shadow,
      .shadow_ok, .shadow_fail, .fail_all, .wr_req, .go_write, .go_die
   );

   // {issue_vld, issue_fu, issue_shadow, ok, fail, fail_all, wr_req, exp_write, exp_die, req}
   localparam int NV = 28;
   localparam logic [28:0] VEC [NV] = '{
      {1'b1,2'd0,1'b1,4'h0,4'h0,1'b0,4'h0,4'h0,4'h0,4'd3},  // R3 shadower 0
      {1'b1,2'd1,1'b0,4'h0,4'h0,1'b0,4'h1,4'h0,4'h0,4'd4},  // R4 shadower 0 held
      {1'b1,2'd2,1'b1,4'h0,4'h0,1'b0,4'h2,4'h0,4'h0,4'd3},  // R3 unit 1 blocked
      {1'b1,2'd3,1'b0,4'h0,4'h0,1'b0,4'h6,4'h0,4'h0,4'd3},  // R3
      {1'b0,2'd0,1'b0,4'h1,4'h0,1'b0,4'hE,4'h0,4'h0,4'd5},  // R5 ok takes effect next
      {1'b0,2'd0,1'b0,4'h0,4'h0,1'b0,4'hF,4'h3,4'h0,4'd5},  // R5 units 0,1 write
      {1'b0,2'd0,1'b0,4'h0,4'h4,1'b0,4'hC,4'h0,4'h8,4'd6},  // R6 fail 2 kills 3
      {1'b0,2'd0,1'b0,4'h0,4'h0,1'b0,4'hF,4'h4,4'h0,4'd6},  // R6 unit 2 survives
      {1'b0,2'd0,1'b0,4'h0,4'h0,1'b0,4'hF,4'h0,4'h0,4'd8},  // R8 all idle
      {1'b1,2'd0,1'b1,4'h0,4'h0,1'b0,4'h0,4'h0,4'h0,4'd7},  // R7
      {1'b1,2'd1,1'b1,4'h0,4'h0,1'b0,4'h0,4'h0,4'h0,4'd7},  // R7
      {1'b1,2'd2,1'b0,4'h0,4'h0,1'b0,4'h0,4'h0,4'h0,4'd7},  // R7
      {1'b0,2'd0,1'b0,4'h0,4'h0,1'b1,4'h0,4'h0,4'h6,4'd7},  // R7 fail-all
      {1'b0,2'd0,1'b0,4'h0,4'h0,1'b0,4'hF,4'h1,4'h0,4'd2},  // R2 unit 0 writes
      {1'b1,2'd0,1'b1,4'h0,4'h0,1'b0,4'h0,4'h0,4'h0,4'd9},  // R9
      {1'b1,2'd1,1'b1,4'h0,4'h0,1'b0,4'h0,4'h0,4'h0,4'd9},  // R9
      {1'b1,2'd2,1'b0,4'h2,4'h0,1'b0,4'h0,4'h0,4'h0,4'd9},  // R9 issue with ok of 1
      {1'b1,2'd3,1'b0,4'h0,4'h1,1'b0,4'h8,4'h0,4'h6,4'd9},  // R9 issue with fail of 0
      {1'b0,2'd0,1'b0,4'h0,4'h0,1'b0,4'hF,4'h9,4'h0,4'd9},  // R9 unit 3 not killed
      {1'b1,2'd0,1'b1,4'h0,4'h0,1'b0,4'h0,4'h0,4'h0,4'd10}, // R10
      {1'b1,2'd1,1'b0,4'h0,4'h0,1'b0,4'h0,4'h0,4'h0,4'd10}, // R10
      {1'b1,2'd1,1'b1,4'h2,4'h2,1'b0,4'h2,4'h0,4'h0,4'd10}, // R10 R11 ignored
      {1'b0,2'd0,1'b0,4'h1,4'h0,1'b0,4'h0,4'h0,4'h0,4'd5},  // R5
      {1'b0,2'd0,1'b0,4'h0,4'h0,1'b0,4'h3,4'h3,4'h0,4'd11}, // R11 unit 1 not shadower
      {1'b1,2'd2,1'b1,4'h0,4'h0,1'b0,4'h0,4'h0,4'h0,4'd12}, // R12
      {1'b1,2'd3,1'b0,4'h0,4'h0,1'b0,4'h0,4'h0,4'h0,4'd12}, // R12
      {1'b0,2'd0,1'b0,4'h4,4'h4,1'b0,4'h0,4'h0,4'h8,4'd12}, // R12 fail wins
      {1'b0,2'd0,1'b0,4'h0,4'h0,1'b0,4'hF,4'h4,4'h0,4'd12}  // R12
   };

   task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp,
                        input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic iv, input logic [1:0] fu, input logic sh,
                        input logic [N-1:0] ok, input logic [N-1:0] fl,
                        input logic fa, input logic [N-1:0] wr);
      @(negedge clk);
      issue_vld = iv; issue_fu = fu; issue_shadow = sh;
      shadow_ok = ok; shadow_fail = fl; fail_all = fa; wr_req = wr;
      #1;
   endtask

   initial begin
      #(5.0 * 5000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      drive(1'b0, 2'd0, 1'b0, '0, '0, 1'b0, 4'hF);
      check("R1", go_write, 4'h0, "go_write in reset");
      check("R1", go_die, 4'h0, "go_die in reset");
      @(negedge clk);
      rst_n = 1'b1;
      drive(1'b0, 2'd0, 1'b0, '0, '0, 1'b0, 4'hF);
      check("R1", go_write, 4'h0, "go_write after reset");

      for (int k = 0; k < NV; k++) begin
         drive(VEC[k][28], VEC[k][27:26], VEC[k][25], VEC[k][24:21], VEC[k][20:17],
               VEC[k][16], VEC[k][15:12]);
         check($sformatf("R%0d", VEC[k][3:0]), go_write, VEC[k][11:8],
               $sformatf("go_write vec %0d", k));
         check($sformatf("R%0d", VEC[k][3:0]), go_die, VEC[k][7:4],
               $sformatf("go_die vec %0d", k));
      end

      // R1: reset in the middle of live shadows leaves every unit idle
      drive(1'b1, 2'd0, 1'b1, '0, '0, 1'b0, 4'h0);
      drive(1'b1, 2'd1, 1'b0, '0, '0, 1'b0, 4'h0);
      @(negedge clk);
      rst_n = 1'b0;
      issue_vld = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      drive(1'b0, 2'd0, 1'b0, '0, '0, 1'b0, 4'hF);
      check("R1", go_write, 4'h0, "go_write after mid-run reset");

      // R2: plain unit issued then writes on the following cycle
      drive(1'b1, 2'd1, 1'b0, '0, '0, 1'b0, 4'h2);
      check("R2", go_write, 4'h0, "go_write in issue cycle");
      drive(1'b0, 2'd0, 1'b0, '0, '0, 1'b0, 4'h2);
      check("R2", go_write, 4'h2, "go_write after issue");
      // R8: retired unit gets nothing more
      drive(1'b0, 2'd0, 1'b0, '0, '0, 1'b0, 4'h2);
      check("R8", go_write, 4'h0, "go_write after retire");
      drive(1'b0, 2'd0, 1'b0, '0, '0, 1'b0, 4'h0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule